// File: doc/BRIEF.md
# Wake Event Capture Register

This block records which sources ended a low-power period and presents the result as one 32-bit read-only status word. It takes 24 GPIO lines with a per-pin wake-enable mask and ten raw power-up event inputs with a wake-select mask. The event inputs are two serial-controller pins, one IRQ whose pin is programmable, two debugger power-up requests, a core-wake request, and the sleep timer's compare A, compare B and wrap. All pin and event inputs are asynchronous and reach the capture logic through two-flop synchronizers.

At the sleep-entry strobe the block clears the status word and its internal event register, takes a snapshot of the pins, and arms capture. While armed, any event pulse is held sticky. At the wake-exit strobe it snapshots the pins again. It then merges the enabled pin changes with the masked events, records whether sleep was skipped, and sets the valid bit last. From then on the word stays frozen until the next sleep entry. A simple read port returns the word one cycle after a read strobe.

Top module: `wake_cause_rec`

## Requirements
- R1: After synchronous reset the status word is zero and `rd_data` is zero.
- R2: On a `wake_exit` strobe while capture is armed, the status word is loaded on that clock edge with bit 31 (valid) set. Bits 23:0 carry GPIO activity, with port A in 7:0, port B in 15:8 and port C in 23:16.
- R3: GPIO activity equals (pin state at sleep entry XOR pin state at wake) AND `gpio_wake_en`, where `gpio_wake_en` uses the same bit layout as the pins.
- R4: A raw event counts only if its bit in `wake_sel` is set. Both `pwr_ev` and `wake_sel` use this layout: bit 0 serial controller 1, bit 1 serial controller 2, bit 2 selectable IRQ, bit 3 unused, bit 4 compare A, bit 5 compare B, bit 6 timer wrap, bit 7 core wake, bit 8 debug power-up request, bit 9 system power-up request.
- R5: A serial-controller-1 event sets status bit 10. A serial-controller-2 event sets status bit 2.
- R6: A selectable-IRQ event sets the status bit numbered by `irq_pin_sel`. A value of 24 or more sets no bit.
- R7: Event bits 9:4 appear shifted left by 20 in status bits 29:24: compare A at 24, compare B at 25, wrap at 26, core wake at 27, debug request at 28, system request at 29.
- R8: A `sleep_entry` strobe clears the status word and the event register. Events that occurred before the entry are not reported.
- R9: Status bit 30 (skipped) equals `skip_sleep` sampled at the `wake_exit` strobe.
- R10: An event pulse seen at any time while armed is reported at wake, even if it has ended. After the valid bit is set, new events, pin changes and further `wake_exit` strobes leave the word unchanged.
- R11: `rd_data` shows the status word in the cycle after `rd_en` is high, and is zero after a cycle with `rd_en` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gpio_in | input | 24 | Asynchronous GPIO pin levels |
| gpio_wake_en | input | 24 | Per-pin wake enable |
| pwr_ev | input | 10 | Asynchronous raw power-up event pulses |
| wake_sel | input | 10 | Wake-select mask for the events |
| irq_pin_sel | input | 5 | GPIO index of the selectable IRQ |
| sleep_entry | input | 1 | Sleep-entry strobe |
| wake_exit | input | 1 | Wake-exit strobe |
| skip_sleep | input | 1 | Sleep was aborted |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Read data |

## Verification
The assertions check several rules on every cycle: the word stays zero while not valid, and skipped is never set without valid. The valid bit rises only after an armed wake strobe, and the word is frozen once valid. They also check that the event register never loses a bit while armed and that read data mirrors the word. The bit mapping itself can only be shown by the bench's scenarios: the XOR-and-mask of pin snapshots, the serial and IRQ remapping, the shift of timer and debug events, masking by wake-select, and the discarding of pre-entry events.

// File: rtl/wake_rec_pkg.sv
package wake_rec_pkg;

    localparam int GPIO_W   = 24;
    localparam int EV_W     = 10;
    localparam int TD_LO    = 4;
    localparam int TD_W     = EV_W - TD_LO;
    localparam int SEL_W    = 5;

    localparam int EV_SER1  = 0;
    localparam int EV_SER2  = 1;
    localparam int EV_IRQ   = 2;

    localparam int SER1_BIT = 10;
    localparam int SER2_BIT = 2;

    typedef struct packed {
        logic              valid;
        logic              skipped;
        logic [TD_W-1:0]   tdbg;
        logic [GPIO_W-1:0] gpio;
    } wake_status_t;

    function automatic logic [GPIO_W-1:0] pin_map(
        input logic [GPIO_W-1:0] act,
        input logic [EV_W-1:0]   ev,
        input logic [SEL_W-1:0]  pin
    );
        logic [GPIO_W-1:0] r;
        r = act;
        if (ev[EV_SER1]) r[SER1_BIT] = 1'b1;
        if (ev[EV_SER2]) r[SER2_BIT] = 1'b1;
        for (int i = 0; i < GPIO_W; i++) begin
            if (ev[EV_IRQ] && (int'(pin) == i)) r[i] = 1'b1;
        end
        return r;
    endfunction

endpackage

// File: rtl/wake_sync.sv
module wake_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[s] <= '0;
                else     stg[s] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[s] <= '0;
                else     stg[s] <= stg[s-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/wake_evt_latch.sv
module wake_evt_latch
    import wake_rec_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            clear,
    input  logic            stop,
    input  logic [EV_W-1:0] ev_in,
    output logic [EV_W-1:0] ev_cap,
    output logic            armed
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ev_cap <= '0;
            armed  <= 1'b0;
        end else if (clear) begin
            ev_cap <= '0;
            armed  <= 1'b1;
        end else if (armed) begin
            ev_cap <= ev_cap | ev_in;
            if (stop) armed <= 1'b0;
        end
    end

    // R10: captured events are sticky while armed
    a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
        (armed && !clear) |=> ((ev_cap & $past(ev_cap)) == $past(ev_cap)));

    // R8: clear empties the register and arms it
    a_r8_clear: assert property (@(posedge clk) disable iff (rst)
        clear |=> (ev_cap == '0 && armed));
endmodule

// File: rtl/wake_compose.sv
module wake_compose
    import wake_rec_pkg::*;
(
    input  logic [GPIO_W-1:0] pins_entry,
    input  logic [GPIO_W-1:0] pins_exit,
    input  logic [GPIO_W-1:0] wake_en,
    input  logic [EV_W-1:0]   ev_cap,
    input  logic [EV_W-1:0]   sel,
    input  logic [SEL_W-1:0]  irq_pin,
    input  logic              skip,
    output wake_status_t      word
);
    logic [EV_W-1:0]   ev_m;
    logic [GPIO_W-1:0] act;

    always_comb begin
        ev_m         = ev_cap & sel;
        act          = (pins_entry ^ pins_exit) & wake_en;
        word.valid   = 1'b1;
        word.skipped = skip;
        word.tdbg    = ev_m[EV_W-1:TD_LO];
        word.gpio    = pin_map(act, ev_m, irq_pin);
    end
endmodule

// File: rtl/wake_cause_rec.sv
module wake_cause_rec
    import wake_rec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [GPIO_W-1:0] gpio_in,
    input  logic [GPIO_W-1:0] gpio_wake_en,
    input  logic [EV_W-1:0]   pwr_ev,
    input  logic [EV_W-1:0]   wake_sel,
    input  logic [SEL_W-1:0]  irq_pin_sel,
    input  logic              sleep_entry,
    input  logic              wake_exit,
    input  logic              skip_sleep,
    input  logic              rd_en,
    output logic [31:0]       rd_data
);
    localparam int SYNC_STAGES = 2;

    logic [GPIO_W-1:0] pins_s, pins_entry;
    logic [EV_W-1:0]   ev_s, ev_cap;
    logic              armed;
    wake_status_t      status, next_word;

    wake_sync #(.W(GPIO_W), .STAGES(SYNC_STAGES)) i_sync_pins (
        .clk(clk), .rst(rst), .d(gpio_in), .q(pins_s));

    wake_sync #(.W(EV_W), .STAGES(SYNC_STAGES)) i_sync_ev (
        .clk(clk), .rst(rst), .d(pwr_ev), .q(ev_s));

    wake_evt_latch i_latch (
        .clk(clk), .rst(rst), .clear(sleep_entry),
        .stop(wake_exit), .ev_in(ev_s), .ev_cap(ev_cap), .armed(armed));

    wake_compose i_compose (
        .pins_entry(pins_entry), .pins_exit(pins_s), .wake_en(gpio_wake_en),
        .ev_cap(ev_cap), .sel(wake_sel), .irq_pin(irq_pin_sel),
        .skip(skip_sleep), .word(next_word));

    always_ff @(posedge clk) begin
        if (rst) begin
            status     <= '0;
            pins_entry <= '0;
        end else if (sleep_entry) begin
            status     <= '0;
            pins_entry <= pins_s;
        end else if (wake_exit && armed) begin
            status     <= next_word;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        rd_data <= '0;
        else if (rd_en) rd_data <= status;
        else            rd_data <= '0;
    end

    // R2: valid rises only after an armed wake strobe
    a_r2_valid_origin: assert property (@(posedge clk) disable iff (rst)
        $rose(status.valid) |-> ($past(wake_exit) && $past(armed)));

    // R8: sleep entry empties the word
    a_r8_entry_clears: assert property (@(posedge clk) disable iff (rst)
        sleep_entry |=> (status == '0));

    // R9: skipped never appears without valid
    a_r9_skip_needs_valid: assert property (@(posedge clk) disable iff (rst)
        status.skipped |-> status.valid);

    // R10: word frozen once valid
    a_r10_frozen: assert property (@(posedge clk) disable iff (rst)
        (status.valid && !sleep_entry) |=> $stable(status));

    // R10: a word without valid carries nothing
    a_r10_empty_until_valid: assert property (@(posedge clk) disable iff (rst)
        !status.valid |-> (status == '0));

    // R11: read data mirrors the word
    a_r11_read: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> (rd_data == $past(status)));
endmodule

// File: tb/test_wake_cause_rec.sv
module test_wake_cause_rec;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [23:0] gpio_in = '0, gpio_wake_en = '0;
    logic [9:0]  pwr_ev = '0, wake_sel = '0;
    logic [4:0]  irq_pin_sel = '0;
    logic        sleep_entry = 1'b0, wake_exit = 1'b0, skip_sleep = 1'b0, rd_en = 1'b0;
    logic [31:0] rd_data;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    wake_cause_rec i_wake_cause_rec (
        .clk(clk), .rst(rst), .gpio_in(gpio_in), .gpio_wake_en(gpio_wake_en),
        .pwr_ev(pwr_ev), .wake_sel(wake_sel), .irq_pin_sel(irq_pin_sel),
        .sleep_entry(sleep_entry), .wake_exit(wake_exit), .skip_sleep(skip_sleep),
        .rd_en(rd_en), .rd_data(rd_data));

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic read_word(output logic [31:0] v);
        rd_en = 1'b1;
        step(1);
        rd_en = 1'b0;
        v = rd_data;
    endtask

    task automatic enter_sleep(input logic [23:0] pins);
        gpio_in = pins;
        step(4);
        sleep_entry = 1'b1;
        step(1);
        sleep_entry = 1'b0;
        step(1);
    endtask

    task automatic pulse(input logic [9:0] ev);
        pwr_ev = ev;
        step(2);
        pwr_ev = '0;
        step(4);
    endtask

    task automatic wake(input logic [23:0] pins, input logic skip);
        gpio_in = pins;
        step(4);
        skip_sleep = skip;
        wake_exit  = 1'b1;
        step(1);
        wake_exit  = 1'b0;
        skip_sleep = 1'b0;
        step(1);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R1 rd_data idle", rd_data, 32'h0);
        read_word(v);
        check("R1 reset word", v, 32'h0);
    endtask

    task automatic t_gpio();
        logic [31:0] v;
        gpio_wake_en = 24'h00FF0F;
        wake_sel = '0;
        enter_sleep(24'h000000);
        wake(24'h0F0F0F, 1'b0);
        read_word(v);
        check("R2 R3 gpio xor mask", v, 32'h80000F0F);
        gpio_wake_en = 24'hFFFFFF;
        enter_sleep(24'hA5A5A5);
        wake(24'hA5A5A4, 1'b0);
        read_word(v);
        check("R3 falling pin", v, 32'h80000001);
        gpio_wake_en = '0;
    endtask

    task automatic t_serial();
        logic [31:0] v;
        wake_sel = 10'h3F7;
        enter_sleep('0);
        pulse(10'b00_0000_0011);
        wake('0, 1'b0);
        read_word(v);
        check("R5 serial map", v, 32'h80000404);
    endtask

    task automatic t_mask_timer();
        logic [31:0] v;
        wake_sel = 10'b00_0001_0000;
        enter_sleep('0);
        pulse(10'b00_0101_0001);
        wake('0, 1'b0);
        read_word(v);
        check("R4 R7 masked events", v, 32'h81000000);
        wake_sel = 10'h3F7;
        enter_sleep('0);
        pulse(10'b11_1111_0000);
        wake('0, 1'b0);
        read_word(v);
        check("R7 six flags", v, 32'hBF000000);
        enter_sleep('0);
        pulse(10'b01_0000_0000);
        wake('0, 1'b0);
        read_word(v);
        check("R7 debug request", v, 32'h90000000);
    endtask

    task automatic t_irq();
        logic [31:0] v;
        wake_sel = 10'h3F7;
        irq_pin_sel = 5'd17;
        enter_sleep('0);
        pulse(10'b00_0000_0100);
        wake('0, 1'b0);
        read_word(v);
        check("R6 irq pin 17", v, 32'h80020000);
        irq_pin_sel = 5'd30;
        enter_sleep('0);
        pulse(10'b00_0000_0100);
        wake('0, 1'b0);
        read_word(v);
        check("R6 irq out of range", v, 32'h80000000);
        irq_pin_sel = '0;
    endtask

    task automatic t_skip();
        logic [31:0] v;
        enter_sleep('0);
        wake('0, 1'b1);
        read_word(v);
        check("R9 skipped", v, 32'hC0000000);
    endtask

    task automatic t_clear();
        logic [31:0] v;
        wake_sel = 10'h3F7;
        enter_sleep('0);
        read_word(v);
        check("R8 entry clears word", v, 32'h0);
        wake('0, 1'b0);
        pulse(10'b00_0001_0000);
        enter_sleep('0);
        wake('0, 1'b0);
        read_word(v);
        check("R8 pre-entry event dropped", v, 32'h80000000);
    endtask

    task automatic t_frozen();
        logic [31:0] v;
        wake_sel = 10'h3F7;
        gpio_wake_en = 24'hFFFFFF;
        enter_sleep('0);
        pulse(10'b00_0010_0000);
        step(10);
        wake('0, 1'b0);
        read_word(v);
        check("R10 sticky event", v, 32'h82000000);
        pulse(10'b00_0100_0000);
        gpio_in = 24'h000003;
        step(4);
        wake(24'h000003, 1'b1);
        read_word(v);
        check("R10 frozen after valid", v, 32'h82000000);
        gpio_wake_en = '0;
        gpio_in = '0;
    endtask

    task automatic t_read_idle();
        step(1);
        check("R11 idle read zero", rd_data, 32'h0);
    endtask

    initial begin
        step(3);
        rst = 1'b0;
        step(1);
        t_reset();
        t_gpio();
        t_serial();
        t_mask_timer();
        t_irq();
        t_skip();
        t_clear();
        t_frozen();
        t_read_idle();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule